// File: doc/BRIEF.md
# Operating-Point Step Sequencer

This block moves a processor core between its full-speed operating point and a reduced-power one when the core enters or leaves its deep idle state. It has two controls: the core clock multiplier code and the supply voltage identification (VID) code. It changes them one at a time and in a fixed order. Going down, the multiplier drops first and the voltage follows. Going up, the voltage rises first while the core still runs at the slow multiplier, and only then is the multiplier restored. The core therefore never runs fast on a low supply. The bus clock is not touched; only the core multiplier changes.

Each step raises a request line beside its code. The step completes either when the downstream agent acknowledges it or when a programmable settle count runs out; a configuration bit chooses which. The two target pairs (high and low multiplier, high and low VID) arrive as configuration inputs. A power-state controller sends one-cycle enter and exit pulses. The block reports progress with a busy level, a one-cycle completion pulse and an at-low-point flag. A request in the opposite direction that arrives mid-sequence is held and served after the current sequence completes.

Top module: `opseq_top`

## Requirements
- R1: After reset, `core_ratio` equals `cfg_ratio_hi`, `core_vid` equals `cfg_vid_hi`, and `seq_busy`, `seq_done`, `at_low`, `ratio_req` and `vid_req` are all 0.
- R2: An `lp_enter` pulse while idle at the high point changes `core_ratio` to `cfg_ratio_lo` first. `core_vid` stays at `cfg_vid_hi` until that step completes, and only then changes to `cfg_vid_lo`.
- R3: An `lp_exit` pulse while idle at the low point changes `core_vid` to `cfg_vid_hi` first, with `core_ratio` held at `cfg_ratio_lo`. Only after the voltage step completes does `core_ratio` return to `cfg_ratio_hi`.
- R4: With `cfg_wait_ack`=1, a step's request rises together with its code change and stays high until the first cycle its acknowledge is high, then drops one cycle later. The next step's code and request change on that same edge.
- R5: With `cfg_wait_ack`=0, each step's request stays high for exactly `cfg_settle`+1 cycles, including when `cfg_settle` is 0, and the acknowledge inputs have no effect.
- R6: `seq_done` pulses high for exactly one cycle, in the cycle after the last step of a sequence completes. `at_low` is 1 from the done pulse that ends an entry until the exit sequence starts, and 0 otherwise.
- R7: `seq_busy` is 1 whenever either request line is high, and 0 when the block is idle with nothing queued.
- R8: An `lp_exit` pulse during an entry sequence is held. Entry runs to completion with its done pulse, and the exit sequence then starts on the next edge. The code order stays VID-after-ratio going down and ratio-after-VID going up.
- R9: `lp_enter` while already at the low point, and `lp_exit` while idle at the high point, change no output.
- R10: `ratio_req` and `vid_req` are never high together, and a code is held constant while its request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ratio_hi | input | RATIO_W | Core multiplier at the full-speed point |
| cfg_ratio_lo | input | RATIO_W | Core multiplier at the reduced point |
| cfg_vid_hi | input | VID_W | Voltage code at the full-speed point |
| cfg_vid_lo | input | VID_W | Voltage code at the reduced point |
| cfg_settle | input | CNT_W | Extra settle cycles per step when not waiting for acknowledge |
| cfg_wait_ack | input | 1 | 1: steps end on acknowledge; 0: steps end on settle count |
| lp_enter | input | 1 | One-cycle request to move to the reduced point |
| lp_exit | input | 1 | One-cycle request to return to the full-speed point |
| core_ratio | output | RATIO_W | Current core multiplier code |
| ratio_req | output | 1 | Multiplier step in progress |
| ratio_ack | input | 1 | Multiplier step acknowledge |
| core_vid | output | VID_W | Current voltage code |
| vid_req | output | 1 | Voltage step in progress |
| vid_ack | input | 1 | Voltage step acknowledge |
| seq_busy | output | 1 | A sequence is running or queued |
| seq_done | output | 1 | One-cycle pulse at sequence completion |
| at_low | output | 1 | Settled at the reduced point |

## Verification
The hardest case to reach is an opposite request that lands inside a running sequence and must be held, not dropped and not acted on early. The bench runs an entry in acknowledge mode with a slow acknowledge responder. While the multiplier step waits, it pulses `lp_exit`, then expects the complete down-then-up event list from the scoreboard. Settle mode is exercised with a zero and a non-zero count while the responder keeps pulsing acknowledges, so that ignoring them is visible in the measured request lengths.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  localparam int unsigned NCH      = 2;
  localparam int unsigned CH_RATIO = 0;
  localparam int unsigned CH_VID   = 1;

  typedef enum logic [2:0] {
    ST_IDLE_HI   = 3'd0,
    ST_ENT_RATIO = 3'd1,
    ST_ENT_VID   = 3'd2,
    ST_IDLE_LO   = 3'd3,
    ST_EXI_VID   = 3'd4,
    ST_EXI_RATIO = 3'd5
  } seq_st_e;

  function automatic logic is_entering(seq_st_e s);
    return (s == ST_ENT_RATIO) || (s == ST_ENT_VID);
  endfunction

  function automatic logic is_exiting(seq_st_e s);
    return (s == ST_EXI_VID) || (s == ST_EXI_RATIO);
  endfunction

endpackage

// File: rtl/opseq_chan.sv
// One step channel: raises req on start, ends on ack or on settle count.
module opseq_chan #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_ack,
  input  logic [CNT_W-1:0] settle,
  input  logic             start,
  input  logic             ack,
  output logic             req,
  output logic             fin
);

  logic             req_q, req_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;
  logic             req_en, cnt_en;

  assign cnt_zero = (cnt_q == '0);
  assign fin      = req_q && (wait_ack ? ack : cnt_zero);
  assign req      = req_q;

  always_comb begin
    req_d  = req_q;
    cnt_d  = cnt_q;
    req_en = 1'b0;
    cnt_en = 1'b0;
    if (start) begin
      req_d  = 1'b1;
      cnt_d  = settle;
      req_en = 1'b1;
      cnt_en = 1'b1;
    end else if (fin) begin
      req_d  = 1'b0;
      req_en = 1'b1;
    end else if (req_q && !wait_ack && !cnt_zero) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_en) begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/opseq_hold.sv
// Holds an opposite-direction request that arrives mid-sequence.
module opseq_hold
  import opseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_e st,
  input  logic    enter_in,
  input  logic    exit_in,
  output logic    go_enter,
  output logic    go_exit,
  output logic    pend
);

  logic pend_q, pend_d, pend_en;
  logic opp_req, idle;

  assign idle    = (st == ST_IDLE_HI) || (st == ST_IDLE_LO);
  assign opp_req = (is_entering(st) && exit_in) || (is_exiting(st) && enter_in);

  assign go_enter = (st == ST_IDLE_HI) && (enter_in || pend_q);
  assign go_exit  = (st == ST_IDLE_LO) && (exit_in  || pend_q);
  assign pend     = pend_q;

  always_comb begin
    pend_d  = pend_q;
    pend_en = 1'b0;
    if (idle && pend_q) begin
      pend_d  = 1'b0;
      pend_en = 1'b1;
    end else if (opp_req) begin
      pend_d  = 1'b1;
      pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/opseq_ctrl.sv
// Step ordering: ratio then VID going down, VID then ratio going up.
module opseq_ctrl
  import opseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_enter,
  input  logic           go_exit,
  input  logic [NCH-1:0] fin,
  output logic [NCH-1:0] start,
  output logic           ratio_sel,
  output logic           vid_sel,
  output logic           done,
  output seq_st_e        st
);

  seq_st_e st_q, st_d;
  logic    rsel_q, rsel_d;
  logic    vsel_q, vsel_d;
  logic    done_q, done_d;

  always_comb begin
    st_d   = st_q;
    rsel_d = rsel_q;
    vsel_d = vsel_q;
    done_d = 1'b0;
    start  = '0;
    unique case (st_q)
      ST_IDLE_HI: begin
        if (go_enter) begin
          st_d            = ST_ENT_RATIO;
          rsel_d          = 1'b1;
          start[CH_RATIO] = 1'b1;
        end
      end
      ST_ENT_RATIO: begin
        if (fin[CH_RATIO]) begin
          st_d          = ST_ENT_VID;
          vsel_d        = 1'b1;
          start[CH_VID] = 1'b1;
        end
      end
      ST_ENT_VID: begin
        if (fin[CH_VID]) begin
          st_d   = ST_IDLE_LO;
          done_d = 1'b1;
        end
      end
      ST_IDLE_LO: begin
        if (go_exit) begin
          st_d          = ST_EXI_VID;
          vsel_d        = 1'b0;
          start[CH_VID] = 1'b1;
        end
      end
      ST_EXI_VID: begin
        if (fin[CH_VID]) begin
          st_d            = ST_EXI_RATIO;
          rsel_d          = 1'b0;
          start[CH_RATIO] = 1'b1;
        end
      end
      ST_EXI_RATIO: begin
        if (fin[CH_RATIO]) begin
          st_d   = ST_IDLE_HI;
          done_d = 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE_HI;
        rsel_d = 1'b0;
        vsel_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE_HI;
      rsel_q <= 1'b0;
      vsel_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rsel_q <= rsel_d;
      vsel_q <= vsel_d;
      done_q <= done_d;
    end
  end

  assign ratio_sel = rsel_q;
  assign vid_sel   = vsel_q;
  assign done      = done_q;
  assign st        = st_q;

endmodule

// File: rtl/opseq_top.sv
module opseq_top
  import opseq_pkg::*;
#(
  parameter int unsigned RATIO_W = 6,
  parameter int unsigned VID_W   = 8,
  parameter int unsigned CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] cfg_ratio_hi,
  input  logic [RATIO_W-1:0] cfg_ratio_lo,
  input  logic [VID_W-1:0]   cfg_vid_hi,
  input  logic [VID_W-1:0]   cfg_vid_lo,
  input  logic [CNT_W-1:0]   cfg_settle,
  input  logic               cfg_wait_ack,
  input  logic               lp_enter,
  input  logic               lp_exit,
  output logic [RATIO_W-1:0] core_ratio,
  output logic               ratio_req,
  input  logic               ratio_ack,
  output logic [VID_W-1:0]   core_vid,
  output logic               vid_req,
  input  logic               vid_ack,
  output logic               seq_busy,
  output logic               seq_done,
  output logic               at_low
);

  seq_st_e        st;
  logic           go_enter, go_exit, pend;
  logic [NCH-1:0] start, fin, req, ack;
  logic           ratio_sel, vid_sel;

  assign ack[CH_RATIO] = ratio_ack;
  assign ack[CH_VID]   = vid_ack;

  opseq_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .enter_in (lp_enter),
    .exit_in  (lp_exit),
    .go_enter (go_enter),
    .go_exit  (go_exit),
    .pend     (pend)
  );

  opseq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_enter  (go_enter),
    .go_exit   (go_exit),
    .fin       (fin),
    .start     (start),
    .ratio_sel (ratio_sel),
    .vid_sel   (vid_sel),
    .done      (seq_done),
    .st        (st)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    opseq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wait_ack (cfg_wait_ack),
      .settle   (cfg_settle),
      .start    (start[g]),
      .ack      (ack[g]),
      .req      (req[g]),
      .fin      (fin[g])
    );
  end

  assign core_ratio = ratio_sel ? cfg_ratio_lo : cfg_ratio_hi;
  assign core_vid   = vid_sel   ? cfg_vid_lo   : cfg_vid_hi;
  assign ratio_req  = req[CH_RATIO];
  assign vid_req    = req[CH_VID];
  assign seq_busy   = !((st == ST_IDLE_HI) || (st == ST_IDLE_LO)) || pend;
  assign at_low     = (st == ST_IDLE_LO);

endmodule

// File: rtl/opseq_chk.sv
module opseq_chk #(
  parameter int unsigned RATIO_W = 6,
  parameter int unsigned VID_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RATIO_W-1:0] core_ratio,
  input logic [VID_W-1:0]   core_vid,
  input logic               ratio_req,
  input logic               vid_req,
  input logic               seq_busy,
  input logic               seq_done,
  input logic               at_low,
  input logic               ratio_sel,
  input logic               vid_sel
);

  a_r10_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ratio_req && vid_req));

  a_r2_vid_after_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_sel) |-> ratio_sel);

  a_r3_ratio_after_vid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ratio_sel) |-> !vid_sel);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  a_r10_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_req && $past(ratio_req)) |-> $stable(core_ratio));

  a_r10_vid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && $past(vid_req)) |-> $stable(core_vid));

  a_r7_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_req || vid_req) |-> seq_busy);

  a_r6_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    at_low |-> (!ratio_req && !vid_req));

endmodule

bind opseq_top opseq_chk #(.RATIO_W(RATIO_W), .VID_W(VID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_ratio (core_ratio),
  .core_vid   (core_vid),
  .ratio_req  (ratio_req),
  .vid_req    (vid_req),
  .seq_busy   (seq_busy),
  .seq_done   (seq_done),
  .at_low     (at_low),
  .ratio_sel  (ratio_sel),
  .vid_sel    (vid_sel)
);

// File: tb/sim_opseq_top.sv
`timescale 1ns/1ps
module sim_opseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int RATIO_W = 6;
  localparam int VID_W   = 8;
  localparam int CNT_W   = 8;
  localparam int ACK_LAT = 3;
  localparam logic [RATIO_W-1:0] R_HI = 6'd12;
  localparam logic [RATIO_W-1:0] R_LO = 6'd6;
  localparam logic [VID_W-1:0]   V_HI = 8'hA0;
  localparam logic [VID_W-1:0]   V_LO = 8'h70;
  localparam int EV_RATIO = 0;
  localparam int EV_VID   = 1;
  localparam int EV_DONE  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_settle = '0;
  logic cfg_wait_ack = 1'b1;
  logic lp_enter = 1'b0, lp_exit = 1'b0;
  logic ratio_ack = 1'b0, vid_ack = 1'b0;
  logic [RATIO_W-1:0] core_ratio;
  logic [VID_W-1:0] core_vid;
  logic ratio_req, vid_req, seq_busy, seq_done, at_low;

  int n_chk = 0, n_fail = 0;
  int exp_kind[$];
  int exp_val[$];
  int exp_len = 0;
  bit mon_on = 1'b0;
  logic [RATIO_W-1:0] prev_r;
  logic [VID_W-1:0] prev_v;
  int run_r = 0, run_v = 0, cnt_ra = 0, cnt_va = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opseq_top #(.RATIO_W(RATIO_W), .VID_W(VID_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_ratio_hi(R_HI), .cfg_ratio_lo(R_LO), .cfg_vid_hi(V_HI), .cfg_vid_lo(V_LO),
    .cfg_settle(cfg_settle), .cfg_wait_ack(cfg_wait_ack),
    .lp_enter(lp_enter), .lp_exit(lp_exit),
    .core_ratio(core_ratio), .ratio_req(ratio_req), .ratio_ack(ratio_ack),
    .core_vid(core_vid), .vid_req(vid_req), .vid_ack(vid_ack),
    .seq_busy(seq_busy), .seq_done(seq_done), .at_low(at_low)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Acknowledge responders: ack after ACK_LAT cycles of request.
  always @(negedge clk) begin
    if (ratio_req && !ratio_ack) begin
      cnt_ra++;
      if (cnt_ra == ACK_LAT) begin ratio_ack <= 1'b1; cnt_ra = 0; end
    end else begin
      ratio_ack <= 1'b0;
      if (!ratio_req) cnt_ra = 0;
    end
    if (vid_req && !vid_ack) begin
      cnt_va++;
      if (cnt_va == ACK_LAT) begin vid_ack <= 1'b1; cnt_va = 0; end
    end else begin
      vid_ack <= 1'b0;
      if (!vid_req) cnt_va = 0;
    end
  end

  // Monitor: compares observed code changes and done pulses with the queue.
  task automatic pop_cmp(input int kind, input int val, input string rq);
    if (exp_kind.size() == 0) begin
      chk(1'b0, {rq, " unexpected event"}, kind*1000 + val, -1);
    end else begin
      int k, v;
      k = exp_kind.pop_front();
      v = exp_val.pop_front();
      chk(k == kind && v == val, rq, kind*1000 + val, k*1000 + v);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (core_ratio != prev_r) pop_cmp(EV_RATIO, int'(core_ratio), "R2/R3 order");
      if (core_vid != prev_v)   pop_cmp(EV_VID, int'(core_vid), "R2/R3 order");
      if (seq_done)             pop_cmp(EV_DONE, 0, "R6 done");
      if (ratio_req) run_r++;
      else if (run_r > 0) begin
        if (exp_len > 0) chk(run_r == exp_len, "R4/R5 ratio_req length", run_r, exp_len);
        run_r = 0;
      end
      if (vid_req) run_v++;
      else if (run_v > 0) begin
        if (exp_len > 0) chk(run_v == exp_len, "R4/R5 vid_req length", run_v, exp_len);
        run_v = 0;
      end
    end
    prev_r = core_ratio;
    prev_v = core_vid;
  end

  task automatic push(input int k, input int v);
    exp_kind.push_back(k);
    exp_val.push_back(v);
  endtask

  task automatic pulse_enter();
    @(negedge clk) lp_enter = 1'b1;
    @(negedge clk) lp_enter = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk) lp_exit = 1'b1;
    @(negedge clk) lp_exit = 1'b0;
  endtask

  task automatic do_enter();
    push(EV_RATIO, int'(R_LO)); push(EV_VID, int'(V_LO)); push(EV_DONE, 0);
    pulse_enter();
  endtask

  task automatic do_exit();
    push(EV_VID, int'(V_HI)); push(EV_RATIO, int'(R_HI)); push(EV_DONE, 0);
    pulse_exit();
  endtask

  task automatic drain(input string rq);
    int t = 0;
    while (exp_kind.size() != 0 && t < 300) begin @(negedge clk); t++; end
    chk(exp_kind.size() == 0, {rq, " sequence completes"}, exp_kind.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(core_ratio == R_HI, "R1 ratio", core_ratio, R_HI);
    chk(core_vid == V_HI, "R1 vid", core_vid, V_HI);
    chk({seq_busy, seq_done, at_low, ratio_req, vid_req} == 5'b0, "R1 flags",
        {seq_busy, seq_done, at_low, ratio_req, vid_req}, 0);
    mon_on = 1'b1;

    // R2/R4: entry in acknowledge mode
    exp_len = ACK_LAT;
    do_enter();
    // now ratio step running: vid must still be high, busy set (R2, R7)
    chk(ratio_req == 1'b1, "R2 ratio step first", ratio_req, 1);
    chk(core_vid == V_HI, "R2 vid held during ratio step", core_vid, V_HI);
    chk(seq_busy == 1'b1, "R7 busy during sequence", seq_busy, 1);
    drain("R2");
    chk(at_low == 1'b1, "R6 at_low after entry", at_low, 1);
    chk(seq_busy == 1'b0, "R7 busy idle", seq_busy, 0);

    // R9: enter while low is ignored
    pulse_enter();
    repeat (10) @(negedge clk);
    chk(core_ratio == R_LO && core_vid == V_LO && !seq_busy, "R9 enter ignored at low",
        {core_ratio, core_vid}, {R_LO, V_LO});

    // R3: exit
    do_exit();
    chk(at_low == 1'b0, "R6 at_low drops on exit", at_low, 0);
    chk(core_ratio == R_LO, "R3 ratio held during vid step", core_ratio, R_LO);
    drain("R3");

    // R9: exit while high is ignored
    pulse_exit();
    repeat (10) @(negedge clk);
    chk(core_ratio == R_HI && core_vid == V_HI && !seq_busy, "R9 exit ignored at high",
        {core_ratio, core_vid}, {R_HI, V_HI});

    // R5: settle mode, acks ignored
    cfg_wait_ack = 1'b0; cfg_settle = 8'd4; exp_len = 5;
    do_enter(); drain("R5 enter");
    do_exit();  drain("R5 exit");
    cfg_settle = 8'd0; exp_len = 1;
    do_enter(); drain("R5 zero enter");
    do_exit();  drain("R5 zero exit");

    // R8: exit queued during entry
    cfg_wait_ack = 1'b1; exp_len = ACK_LAT;
    push(EV_RATIO, int'(R_LO)); push(EV_VID, int'(V_LO)); push(EV_DONE, 0);
    push(EV_VID, int'(V_HI)); push(EV_RATIO, int'(R_HI)); push(EV_DONE, 0);
    pulse_enter();
    pulse_exit();
    chk(seq_busy == 1'b1, "R8 busy while queued", seq_busy, 1);
    drain("R8");
    chk(at_low == 1'b0 && core_ratio == R_HI, "R8 ends at high point", at_low, 0);

    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule